// File: doc/BRIEF.md
# Display Wake Request Controller

This block produces one wake request that keeps the display memory path out of its low-power state while a queue of register writes runs ahead of vertical blank. Software programs a target scanline (normally the active line count less the memory latency expressed in lines) and an enable. A commit pulse, issued with the wait-for-vblank mode flag, arms the block. The block then watches the scanline counter and raises the wake request once the current line reaches the target.

At commit time the block also checks how close the scanner already is to the target. If the target lies zero to four lines ahead, a sticky force bit is set at once, so that the wake is not lost when the counter passes the target before the armed window can see it. The force bit is cleared only by an explicit clear, whether or not the command engine is still running. The window ends at the first line of vertical blank. It may be carried past that point while the engine is still busy, unless the block-extension control is set.

All scanline numbers use the counter's own modulo-vtotal numbering.

Top module: `wake_ctl_top`

## Requirements
- R1: After reset, wake_o is 0 and no source of wake is active.
- R2: A commit with wait mode set and the enable set, where target_line_i minus cur_line_i is from 0 to 4 inclusive, raises wake_o on the next cycle through the force bit. A force_set_i pulse also sets the force bit.
- R3: A commit where target minus current is 5 or more, or is negative, does not raise wake_o on the next cycle.
- R4: Once a commit in wait mode has armed the block, wake_o rises the cycle after cur_line_i equals target_line_i while the enable is set, and is 0 before that.
- R5: The window ends when cur_line_i equals vblank_line_i. With block_ext_i set and force clear, wake_o is 0 from the next cycle.
- R6: With block_ext_i clear and engine_busy_i high at vblank start, wake_o stays 1 past vblank start. It falls the cycle after engine_busy_i goes low.
- R7: The force bit keeps wake_o at 1 after the engine goes idle and through vertical blank. Only force_clr_i clears it, with effect on the next cycle. Set has priority over clear.
- R8: A commit with wait mode clear disarms the block: no window opens and no force is set.
- R9: With wake_en_i low, neither a near commit nor a target match asserts wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_en_i | input | 1 | Enables wake by target scanline |
| target_line_i | input | LINE_W | Scanline at which wake starts |
| cur_line_i | input | LINE_W | Current scanline from the counter |
| vblank_line_i | input | LINE_W | First line of vertical blank |
| wait_vblank_i | input | 1 | Wait-for-vblank mode, sampled on commit |
| commit_i | input | 1 | One-cycle commit pulse |
| force_set_i | input | 1 | Explicit write setting the force bit |
| force_clr_i | input | 1 | Explicit write clearing the force bit |
| block_ext_i | input | 1 | Stops wake from extending past vblank start |
| engine_busy_i | input | 1 | Command engine is running |
| wake_o | output | 1 | Wake request |

## Verification
A free-running scanline sweep is driven while commits land at several distances from the target: 0, 3, 4, 5 and −1 lines. These separate the proximity boundary on both sides and the wrap into the following frame. Separate frames toggle block-extension and engine busy to tell a window that ends at vblank start from one that is extended. A forced frame with the engine idle shows that the force bit is sticky. Commits with the enable low or wait mode clear show that they are ignored at the wake output.

// File: rtl/wake_ctl_pkg.sv
package wake_ctl_pkg;
  typedef struct packed {
    logic force_on;
    logic window;
    logic extend;
  } wake_src_t;
endpackage

// File: rtl/wake_near_det.sv
module wake_near_det #(
  parameter int LINE_W     = 13,
  parameter int NEAR_LINES = 5
) (
  input  logic [LINE_W-1:0] target_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              near_o
);
  localparam int DW = LINE_W + 1;
  logic [DW-1:0] diff;

  always_comb begin
    diff   = {1'b0, target_i} - {1'b0, line_i};
    // sign bit set means the target is already behind
    near_o = !diff[DW-1] && (diff < DW'(NEAR_LINES));
  end
endmodule

// File: rtl/wake_force_reg.sv
module wake_force_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic force_o
);
  logic force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      force_q <= 1'b0;
    else if (set_i)   force_q <= 1'b1;
    else if (clr_i)   force_q <= 1'b0;
  end

  assign force_o = force_q;

  p_force_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_q && !clr_i) |=> force_q);
  p_force_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> force_q);
endmodule

// File: rtl/wake_window.sv
module wake_window #(
  parameter int LINE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              wait_i,
  input  logic              en_i,
  input  logic [LINE_W-1:0] target_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] vbl_line_i,
  input  logic              busy_i,
  input  logic              block_ext_i,
  output logic              win_o,
  output logic              ext_o
);
  logic mode_q, win_q, ext_q;
  logic at_vbl, at_tgt, win_end;

  assign at_vbl  = (line_i == vbl_line_i);
  assign at_tgt  = (line_i == target_i);
  assign win_end = win_q && at_vbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      win_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      if (commit_i)     mode_q <= wait_i;
      else if (win_end) mode_q <= 1'b0;

      if (at_vbl)                       win_q <= 1'b0;
      else if (mode_q && en_i && at_tgt) win_q <= 1'b1;

      if (!busy_i)                        ext_q <= 1'b0;
      else if (win_end && !block_ext_i)   ext_q <= 1'b1;
    end
  end

  assign win_o = win_q;
  assign ext_o = ext_q;

  p_win_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && at_vbl) |=> !win_q);
  p_ext_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !ext_q);
  p_disarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !wait_i) |=> !mode_q);
endmodule

// File: rtl/wake_ctl_top.sv
module wake_ctl_top
  import wake_ctl_pkg::*;
#(
  parameter int LINE_W     = 13,
  parameter int NEAR_LINES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_en_i,
  input  logic [LINE_W-1:0] target_line_i,
  input  logic [LINE_W-1:0] cur_line_i,
  input  logic [LINE_W-1:0] vblank_line_i,
  input  logic              wait_vblank_i,
  input  logic              commit_i,
  input  logic              force_set_i,
  input  logic              force_clr_i,
  input  logic              block_ext_i,
  input  logic              engine_busy_i,
  output logic              wake_o
);
  wake_src_t src;
  logic      near, near_hit;

  wake_near_det #(.LINE_W(LINE_W), .NEAR_LINES(NEAR_LINES)) u_near (
    .target_i (target_line_i),
    .line_i   (cur_line_i),
    .near_o   (near)
  );

  assign near_hit = commit_i && wait_vblank_i && wake_en_i && near;

  wake_force_reg u_force (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (near_hit || force_set_i),
    .clr_i   (force_clr_i),
    .force_o (src.force_on)
  );

  wake_window #(.LINE_W(LINE_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit_i),
    .wait_i      (wait_vblank_i),
    .en_i        (wake_en_i),
    .target_i    (target_line_i),
    .line_i      (cur_line_i),
    .vbl_line_i  (vblank_line_i),
    .busy_i      (engine_busy_i),
    .block_ext_i (block_ext_i),
    .win_o       (src.window),
    .ext_o       (src.extend)
  );

  assign wake_o = |src;

  p_near_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    near_hit |=> wake_o);
  p_no_src_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_en_i && !src.force_on && !force_set_i && !engine_busy_i) |=> !src.force_on);
endmodule

// File: tb/wake_ctl_top_tb_top.sv
`timescale 1ns/1ps
module wake_ctl_top_tb_top;
  localparam int LW = 13;
  localparam int VT = 40;
  localparam int WD_LIMIT = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, wait_v = 1'b0, commit = 1'b0, fset = 1'b0, fclr = 1'b0;
  logic bext = 1'b1, busy = 1'b0;
  logic [LW-1:0] tgt = LW'(20), line = '0, vbl = LW'(30);
  logic wake;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, live = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_force = 0, m_mode = 0, m_win = 0, m_ext = 0;

  always #2 clk = ~clk;

  wake_ctl_top #(.LINE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wake_en_i(en), .target_line_i(tgt),
    .cur_line_i(line), .vblank_line_i(vbl), .wait_vblank_i(wait_v),
    .commit_i(commit), .force_set_i(fset), .force_clr_i(fclr),
    .block_ext_i(bext), .engine_busy_i(busy), .wake_o(wake)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      int d;
      bit nf, nm, nw, ne, endw;
      d = int'(tgt) - int'(line);
      endw = m_win && (line == vbl);
      nf = m_force;
      if (fset || (commit && wait_v && en && d >= 0 && d <= 4)) nf = 1;
      else if (fclr) nf = 0;
      nm = commit ? wait_v : (endw ? 0 : m_mode);
      nw = (line == vbl) ? 0 : ((m_mode && en && line == tgt) ? 1 : m_win);
      ne = !busy ? 0 : ((endw && !bext) ? 1 : m_ext);
      m_force = nf; m_mode = nm; m_win = nw; m_ext = ne;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      bit exp;
      exp = m_force | m_win | m_ext;
      checks++;
      if (wake !== exp) begin
        fails++;
        $display("FAIL %s model line=%0d wake=%b exp=%b", tag, line, wake, exp);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog cycles=%0d exp<%0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic step();
    @(negedge clk);
    line = LW'((int'(line) + 1) % VT);
    commit = 0; fset = 0; fclr = 0;
  endtask

  task automatic go(input int l);
    for (int i = 0; i < VT && int'(line) != l; i++) step();
  endtask

  task automatic chk(input string r, input bit exp);
    checks++;
    if (wake !== exp) begin
      fails++;
      $display("FAIL %s line=%0d wake=%b exp=%b", r, line, wake, exp);
    end
  endtask

  task automatic commit_at(input int l, input bit w);
    go(l);
    wait_v = w; commit = 1;
    step();
  endtask

  task automatic clear_force();
    fclr = 1;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 1'b0);
    live = 1;

    // window with block-extension set
    tag = "R4";
    commit_at(5, 1);
    go(20); chk("R4", 1'b0);
    step(); chk("R4", 1'b1);
    go(25); chk("R4", 1'b1);
    tag = "R5";
    go(31); chk("R5", 1'b0);
    go(32); chk("R5", 1'b0);

    // proximity boundaries
    tag = "R2";
    commit_at(17, 1); chk("R2", 1'b1);
    clear_force(); chk("R2", 1'b0);
    go(35);
    commit_at(16, 1); chk("R2", 1'b1);
    clear_force(); chk("R2", 1'b1 && 1'b0);
    go(35);
    tag = "R3";
    commit_at(15, 1); chk("R3", 1'b0);
    go(35);
    commit_at(21, 1); chk("R3", 1'b0);
    tag = "R2";
    commit_at(20, 1); chk("R2", 1'b1);
    clear_force();
    go(35);

    // extension while busy
    tag = "R6";
    bext = 0; busy = 1;
    commit_at(5, 1);
    go(32); chk("R6", 1'b1);
    go(38); chk("R6", 1'b1);
    busy = 0; step(); chk("R6", 1'b0);
    bext = 1;

    // sticky force
    tag = "R7";
    go(2); busy = 1; fset = 1; step(); chk("R7", 1'b1);
    busy = 0;
    go(35); chk("R7", 1'b1);
    step(); go(10); chk("R7", 1'b1);
    clear_force(); chk("R7", 1'b0);

    // enable low
    tag = "R9";
    en = 0;
    commit_at(18, 1); chk("R9", 1'b0);
    go(25); chk("R9", 1'b0);
    go(35);

    // wait mode clear disarms
    tag = "R8";
    en = 1;
    commit_at(10, 0);
    go(22); chk("R8", 1'b0);
    go(28); chk("R8", 1'b0);
    commit_at(18, 0); chk("R8", 1'b0);
    go(35);

    summary();
  end
endmodule